// File: doc/BRIEF.md
# Program Memory Readout Protection Gate

This block stands between an external programming and readout port and an on-chip one-time-programmable program store with its one-byte option register. It decides, request by request, whether an external access reaches the store. The decision rests on a protection flag kept inside the option byte. While the flag is clear, reads return stored words, programming clears bits in the addressed word, and the option byte can be rewritten. While the flag is set, every external read of program memory returns all ones. Programming and option writes are refused, and each refusal raises a one-cycle reject pulse. The option byte itself stays readable at all times.

An erase command sweeps the whole store back to the erased value (all ones), one word per cycle. It also returns every option bit to zero except the protection flag. Once set, the flag survives writes and erases. A protected part can therefore still be erased, but it can never be programmed again.

A single state machine sequences the work. Its states are `ST_IDLE` (accept one request), `ST_RD_RESP` (present read data), `ST_CFG_RESP` (present the option byte), `ST_WR_ACK` (acknowledge an accepted write), `ST_REJECT` (signal a refused write) and `ST_ERASE` (sweep the store). The transitions are as follows. `ST_IDLE` goes to `ST_ERASE` on an erase command. It goes to `ST_CFG_RESP`, `ST_WR_ACK` or `ST_REJECT` on an option request, and to `ST_RD_RESP`, `ST_WR_ACK` or `ST_REJECT` on a memory request, with priority erase, then option, then memory. `ST_ERASE` returns to `ST_IDLE` after the last address. Every other state returns to `ST_IDLE` after one cycle.

Top module: `otp_secure_gate`

## Requirements
- R1: After reset, the machine is idle with all response strobes low. The option byte reads 0x00 and every program word reads all ones.
- R2: With the protection flag clear, a memory read issued in one cycle raises `host_rvalid` in the next cycle, and `host_rdata` carries the stored word.
- R3: An accepted program write stores old AND write data in the addressed word, and `wr_ack` pulses for one cycle in the following cycle.
- R4: With the protection flag set (option bit SEC_BIT, default bit 3, value 1), every memory read returns all ones in `host_rdata`.
- R5: With the protection flag set, a program write leaves memory untouched, raises `wr_reject` in the following cycle and gives no `wr_ack`.
- R6: The option byte is returned on `cfg_rdata` with `cfg_rvalid` one cycle after an option read, whether or not protection is on. An accepted option write replaces the byte.
- R7: With the protection flag set, an option write is refused with `wr_reject`, and the option byte reads back unchanged.
- R8: Once set, the protection flag is never cleared, by option writes or by erase.
- R9: An erase command holds `erase_busy` high for exactly DEPTH cycles. It leaves every program word at all ones and clears every option bit except the protection flag.
- R10: After an erase of a protected part, program and option writes remain refused.
- R11: In the idle state, erase has priority over option requests, and option requests have priority over memory requests. Requests made while a response or erase is in progress are dropped.
- R12: `wr_reject` is never high in two consecutive cycles for one refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| host_req | input | 1 | Memory access request, sampled in idle |
| host_we | input | 1 | 1 = program write, 0 = read |
| host_addr | input | ADDR_W | Program memory word address |
| host_wdata | input | DATA_W | Program write data |
| host_rdata | output | DATA_W | Read data, all ones when protected, zero when not valid |
| host_rvalid | output | 1 | Read data valid |
| cfg_req | input | 1 | Option byte access request |
| cfg_we | input | 1 | 1 = option write, 0 = option read |
| cfg_wdata | input | CFG_W | Option write data |
| cfg_rdata | output | CFG_W | Current option byte |
| cfg_rvalid | output | 1 | Option read response |
| wr_ack | output | 1 | One-cycle pulse: write accepted |
| wr_reject | output | 1 | One-cycle pulse: write refused |
| erase_cmd | input | 1 | Start a full erase sweep |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The bench builds the gate with ADDR_W set to 4, so the store holds sixteen words and a whole erase sweep lasts only sixteen cycles. This keeps the exact busy length, the last address and the post-erase contents cheap to check, both before and after the part is protected. The protection flag stays at the default bit 3. With the option values used (0x55 clear, 0x5D protected), a wrong bit index would show up as a missing mask or a missing lockout.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_RESP  = 3'd1,
        ST_CFG_RESP = 3'd2,
        ST_WR_ACK   = 3'd3,
        ST_REJECT   = 3'd4,
        ST_ERASE    = 3'd5
    } gate_state_t;

    function automatic logic [31:0] pow2(input int unsigned w);
        return 32'd1 << w;
    endfunction

endpackage

// File: rtl/otp_prog_array.sv
module otp_prog_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] erase_addr
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Erased cells read as ones; programming can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (erase_en) begin
            cells[erase_addr] <= '1;
        end else if (prog_en) begin
            cells[prog_addr] <= cells[prog_addr] & prog_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= cells[rd_addr];
    end

    // R9: sweep and programming never collide
    p_no_prog_during_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_en && prog_en));

endmodule

// File: rtl/otp_cfg_store.sv
module otp_cfg_store #(
    parameter int CFG_W   = 8,
    parameter int SEC_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             erase_clr,
    output logic [CFG_W-1:0] cfg_q,
    output logic             secured
);
    localparam logic [CFG_W-1:0] SEC_MASK = CFG_W'(1) << SEC_BIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (erase_clr) begin
            cfg_q <= cfg_q & SEC_MASK;
        end else if (wr_en) begin
            cfg_q <= wr_data | (cfg_q & SEC_MASK);
        end
    end

    assign secured = cfg_q[SEC_BIT];

    // R8: protection flag is sticky
    p_sec_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        secured |=> secured);

    // R7: a protected option byte only changes through an erase
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && !erase_clr) |=> $stable(cfg_q));

endmodule

// File: rtl/otp_gate_fsm.sv
module otp_gate_fsm
    import otp_guard_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic              erase_cmd,
    input  logic              secured,
    output logic              mem_rd_en,
    output logic              mem_prog_en,
    output logic              cfg_wr_en,
    output logic              erase_start,
    output logic              erase_en,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              erase_busy,
    output logic              mem_rvalid,
    output logic              cfg_rvalid,
    output logic              wr_ack,
    output logic              wr_reject
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    gate_state_t state, nxt;
    logic [ADDR_W-1:0] sweep_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sweep_cnt <= '0;
        else if (erase_start)       sweep_cnt <= '0;
        else if (state == ST_ERASE) sweep_cnt <= sweep_cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (erase_cmd)     nxt = ST_ERASE;
                else if (cfg_req)  nxt = !cfg_we ? ST_CFG_RESP
                                       : (secured ? ST_REJECT : ST_WR_ACK);
                else if (host_req) nxt = !host_we ? ST_RD_RESP
                                       : (secured ? ST_REJECT : ST_WR_ACK);
            end
            ST_ERASE:    if (sweep_cnt == LAST_ADDR) nxt = ST_IDLE;
            ST_RD_RESP,
            ST_CFG_RESP,
            ST_WR_ACK,
            ST_REJECT:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_prog_en = 1'b0;
        cfg_wr_en   = 1'b0;
        erase_start = 1'b0;
        erase_en    = 1'b0;
        erase_busy  = 1'b0;
        mem_rvalid  = 1'b0;
        cfg_rvalid  = 1'b0;
        wr_ack      = 1'b0;
        wr_reject   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                erase_start = erase_cmd;
                cfg_wr_en   = !erase_cmd && cfg_req && cfg_we && !secured;
                mem_rd_en   = !erase_cmd && !cfg_req && host_req && !host_we;
                mem_prog_en = !erase_cmd && !cfg_req && host_req && host_we && !secured;
            end
            ST_RD_RESP:  mem_rvalid = 1'b1;
            ST_CFG_RESP: cfg_rvalid = 1'b1;
            ST_WR_ACK:   wr_ack     = 1'b1;
            ST_REJECT:   wr_reject  = 1'b1;
            ST_ERASE: begin
                erase_en   = 1'b1;
                erase_busy = 1'b1;
            end
            default: ;
        endcase
    end

    assign erase_addr = sweep_cnt;

    // R12: a refusal is a single-cycle pulse
    p_reject_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> !wr_reject);

    // R11: no new access starts while the sweep runs
    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> !(mem_rd_en || mem_prog_en || cfg_wr_en));

    // R3: an acknowledge follows the accepted write
    p_ack_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog_en || cfg_wr_en) |=> wr_ack);

endmodule

// File: rtl/otp_secure_gate.sv
module otp_secure_gate #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int CFG_W   = 8,
    parameter int SEC_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              cfg_rvalid,
    output logic              wr_ack,
    output logic              wr_reject,
    input  logic              erase_cmd,
    output logic              erase_busy
);
    logic              secured;
    logic              mem_rd_en, mem_prog_en, cfg_wr_en;
    logic              erase_start, erase_en;
    logic [ADDR_W-1:0] erase_addr;
    logic [DATA_W-1:0] arr_q;
    logic              mem_rvalid;
    logic [CFG_W-1:0]  cfg_q;

    otp_gate_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .cfg_req     (cfg_req),
        .cfg_we      (cfg_we),
        .erase_cmd   (erase_cmd),
        .secured     (secured),
        .mem_rd_en   (mem_rd_en),
        .mem_prog_en (mem_prog_en),
        .cfg_wr_en   (cfg_wr_en),
        .erase_start (erase_start),
        .erase_en    (erase_en),
        .erase_addr  (erase_addr),
        .erase_busy  (erase_busy),
        .mem_rvalid  (mem_rvalid),
        .cfg_rvalid  (cfg_rvalid),
        .wr_ack      (wr_ack),
        .wr_reject   (wr_reject)
    );

    otp_prog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (mem_rd_en),
        .rd_addr    (host_addr),
        .rd_q       (arr_q),
        .prog_en    (mem_prog_en),
        .prog_addr  (host_addr),
        .prog_data  (host_wdata),
        .erase_en   (erase_en),
        .erase_addr (erase_addr)
    );

    otp_cfg_store #(.CFG_W(CFG_W), .SEC_BIT(SEC_BIT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wdata),
        .erase_clr (erase_start),
        .cfg_q     (cfg_q),
        .secured   (secured)
    );

    assign host_rvalid = mem_rvalid;
    assign host_rdata  = !mem_rvalid ? '0 : (secured ? '1 : arr_q);
    assign cfg_rdata   = cfg_q;

    // R4: protected reads leave the gate as all ones
    p_masked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && secured) |-> (host_rdata == '1));

    // R5: program path stays closed once protection is on
    p_no_prog_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_prog_en && secured));

endmodule

// File: tb/otp_secure_gate_test.sv
module otp_secure_gate_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 0, host_we = 0, cfg_req = 0, cfg_we = 0, erase_cmd = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [CW-1:0] cfg_rdata;
    logic host_rvalid, cfg_rvalid, wr_ack, wr_reject, erase_busy;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    otp_secure_gate #(.ADDR_W(AW), .DATA_W(DW), .CFG_W(CW), .SEC_BIT(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .wr_ack(wr_ack), .wr_reject(wr_reject),
        .erase_cmd(erase_cmd), .erase_busy(erase_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mem_read(input logic [AW-1:0] a, output logic v, output logic [DW-1:0] d);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = a;
        @(negedge clk);
        v = host_rvalid; d = host_rdata;
        host_req = 0;
    endtask

    task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             output logic ack, output logic rej);
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        ack = wr_ack; rej = wr_reject;
        host_req = 0; host_we = 0;
    endtask

    task automatic cfg_read(output logic v, output logic [CW-1:0] d);
        @(negedge clk);
        cfg_req = 1; cfg_we = 0;
        @(negedge clk);
        v = cfg_rvalid; d = cfg_rdata;
        cfg_req = 0;
    endtask

    task automatic cfg_write(input logic [CW-1:0] d, output logic ack, output logic rej);
        @(negedge clk);
        cfg_req = 1; cfg_we = 1; cfg_wdata = d;
        @(negedge clk);
        ack = wr_ack; rej = wr_reject;
        cfg_req = 0; cfg_we = 0;
    endtask

    // erase with an optional competing read held for the whole sweep
    task automatic do_erase(input logic with_read, output int busy_cycles, output int stray);
        busy_cycles = 0; stray = 0;
        @(negedge clk);
        erase_cmd = 1;
        if (with_read) begin host_req = 1; host_we = 0; host_addr = '0; end
        @(negedge clk);
        erase_cmd = 0;
        while (erase_busy && busy_cycles < 1000) begin
            busy_cycles++;
            if (host_rvalid || wr_ack || wr_reject) stray++;
            @(negedge clk);
        end
        host_req = 0;
    endtask

    task automatic t_reset;
        logic v; logic [DW-1:0] d; logic [CW-1:0] c;
        check("R1 rvalid", host_rvalid, 0);
        check("R1 ack/reject", {wr_ack, wr_reject}, 0);
        check("R1 busy", erase_busy, 0);
        cfg_read(v, c);
        check("R1 cfg valid", v, 1);
        check("R1 cfg value", c, 8'h00);
        mem_read(4'd5, v, d);
        check("R1 erased word", d, 8'hFF);
    endtask

    task automatic t_program;
        logic v, a, r; logic [DW-1:0] d;
        mem_write(4'd3, 8'hA5, a, r);
        check("R3 ack", {a, r}, 2'b10);
        @(negedge clk);
        check("R3 ack one cycle", wr_ack, 0);
        mem_read(4'd3, v, d);
        check("R2 rvalid", v, 1);
        check("R2 data", d, 8'hA5);
        mem_write(4'd3, 8'h0F, a, r);
        mem_read(4'd3, v, d);
        check("R3 and-programming", d, 8'h05);
        mem_write(4'd15, 8'h3C, a, r);
        mem_read(4'd15, v, d);
        check("R2 last address", d, 8'h3C);
        mem_read(4'd0, v, d);
        check("R2 untouched word", d, 8'hFF);
    endtask

    task automatic t_cfg_open;
        logic v, a, r; logic [CW-1:0] c;
        cfg_write(8'h55, a, r);
        check("R6 cfg write ack", {a, r}, 2'b10);
        cfg_read(v, c);
        check("R6 cfg readback", c, 8'h55);
    endtask

    task automatic t_priority_erase;
        int n, s; logic v; logic [DW-1:0] d; logic [CW-1:0] c;
        do_erase(1'b1, n, s);
        check("R9 busy length", n, DEPTH);
        check("R11 request dropped during erase", s, 0);
        mem_read(4'd3, v, d);
        check("R9 word erased", d, 8'hFF);
        mem_read(4'd15, v, d);
        check("R9 last word erased", d, 8'hFF);
        cfg_read(v, c);
        check("R9 options cleared", c, 8'h00);
    endtask

    task automatic t_cfg_priority;
        logic a; logic [CW-1:0] c;
        // option read and memory write together: option wins, memory write dropped
        @(negedge clk);
        cfg_req = 1; cfg_we = 0; host_req = 1; host_we = 1; host_addr = 4'd7; host_wdata = 8'h00;
        @(negedge clk);
        check("R11 option wins", cfg_rvalid, 1);
        a = wr_ack;
        check("R11 memory write not acked", a, 0);
        cfg_req = 0; host_req = 0; host_we = 0;
        begin
            logic v; logic [DW-1:0] d;
            mem_read(4'd7, v, d);
            check("R11 dropped write left word", d, 8'hFF);
        end
        c = cfg_rdata;
        check("R6 cfg still zero", c, 8'h00);
    endtask

    task automatic t_secure;
        logic v, a, r; logic [DW-1:0] d; logic [CW-1:0] c;
        mem_write(4'd2, 8'h81, a, r);
        cfg_write(8'h55, a, r);
        cfg_write(8'h5D, a, r);
        check("R6 protect write ack", {a, r}, 2'b10);
        cfg_read(v, c);
        check("R6 cfg readable when protected", {v, c}, {1'b1, 8'h5D});
        mem_read(4'd2, v, d);
        check("R4 masked read", {v, d}, {1'b1, 8'hFF});
        mem_write(4'd2, 8'h00, a, r);
        check("R5 write refused", {a, r}, 2'b01);
        @(negedge clk);
        check("R12 reject one cycle", wr_reject, 0);
        cfg_write(8'h00, a, r);
        check("R7 cfg write refused", {a, r}, 2'b01);
        cfg_read(v, c);
        check("R7 cfg unchanged", c, 8'h5D);
        check("R8 flag kept", c[3], 1);
    endtask

    task automatic t_secure_erase;
        int n, s; logic v, a, r; logic [DW-1:0] d; logic [CW-1:0] c;
        do_erase(1'b0, n, s);
        check("R9 busy length protected", n, DEPTH);
        cfg_read(v, c);
        check("R8 flag survives erase", c, 8'h08);
        mem_write(4'd1, 8'h00, a, r);
        check("R10 program refused after erase", {a, r}, 2'b01);
        cfg_write(8'h00, a, r);
        check("R10 cfg write refused after erase", {a, r}, 2'b01);
        cfg_read(v, c);
        check("R10 cfg after refused write", c, 8'h08);
        mem_read(4'd1, v, d);
        check("R4 masked after erase", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_cfg_open();
        t_priority_erase();
        t_cfg_priority();
        t_secure();
        t_secure_erase();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule